// File: doc/BRIEF.md
# Multi-Format Two-Channel Serial Audio Receiver

This block is the slave-side front end of a serial audio port. It takes a serial data line together with an externally generated bit clock, a left/right channel clock and an optional word clock. From these it builds parallel 16-bit left and right samples, each reported with a one-cycle valid strobe. All serial lines are sampled in the system clock domain. Edges on the serial clocks are found after a two-flop synchronizer, so the serial clocks must be slower than the system clock.

A 2-bit format input selects where a word begins relative to the framing clocks. A polarity input selects which bit-clock edge samples the data. A word-length input sets how many bits make up each channel word. The bit clock may stop between bits, and the receiver keeps a partly received word across such a pause. Samples are two's complement, sent MSB first. A word shorter than 16 bits is left-aligned in the output, with zeros below it.

Top module: `srx_multifmt`

## Requirements
- R1: A synchronous active-high `rst` clears `left_o` and `right_o` to zero and holds both strobes low.
- R2: With `bpol_i` = 0, data is sampled on rising `bclk_i` edges. With `bpol_i` = 1, data is sampled on falling edges. The opposite edge never samples data.
- R3: Format `fmt_i` = 2'b00: any `lrck_i` transition starts a word, and the MSB is taken at the first active bit-clock edge after that transition.
- R4: Format 2'b01: a word starts at an `lrck_i` transition, the first active edge after it is skipped, and the MSB is taken at the second.
- R5: Format 2'b10: a word starts at an `lrck_i` transition, sixteen active edges are skipped, and the MSB is taken at the seventeenth.
- R6: Format 2'b11: a rising edge on `wclk_i` starts a word, and the MSB is taken at the first active edge after it. The channel is the `lrck_i` level at that rising edge, and `lrck_i` transitions start nothing. In the other three formats `wclk_i` has no effect.
- R7: A word started while `lrck_i` is high goes to `left_o`. A word started while it is low goes to `right_o`. Each output changes only in the cycle its own strobe is high.
- R8: `wlen_i` gives the bits per word, 4 to 16; smaller values act as 4 and larger as 16. The received bits fill the top of the 16-bit output and the lower 16 − length bits are zero. Data bits after the last one, up to the next word start, are ignored.
- R9: The bit clock may stop at any level for any time. Only actual active edges advance the word, and a partial word is kept across the pause.
- R10: A strobe is high for exactly one system cycle, and never both strobes at once. It rises, with the new sample, at the third rising `clk` edge after the word's last active bit-clock edge reaches the pins.
- R11: After reset, no word is captured and no strobe appears until the first word start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Serial data, MSB first |
| bclk_i | input | 1 | Bit clock from the transmitter, may be gated |
| lrck_i | input | 1 | Channel clock, high = left |
| wclk_i | input | 1 | Word clock, used in format 2'b11 only |
| fmt_i | input | 2 | Framing format select |
| bpol_i | input | 1 | Bit-clock sampling polarity |
| wlen_i | input | 5 | Word length in bits (4 to 16) |
| left_o | output | 16 | Last complete left sample, left-aligned |
| right_o | output | 16 | Last complete right sample, left-aligned |
| left_vld_o | output | 1 | One-cycle strobe for a new left sample |
| right_vld_o | output | 1 | One-cycle strobe for a new right sample |

## Verification
The assertions take for granted that every serial line stays at each level for at least two system cycles. This lets the synchronizer see each edge. They also assume that `wlen_i`, `fmt_i` and `bpol_i` are changed only while no word is in progress, so the zero-fill check reads the length that built the word. The stimulus holds each bit-clock phase for at least three system cycles. It changes data, channel and word clocks only together with the inactive bit-clock edge. It sets the format, polarity and length only in the quiet gap between frames, after the last strobe has settled.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ     = 2'b00,
    FMT_LJ_DLY = 2'b01,
    FMT_RJ     = 2'b10,
    FMT_WCLK   = 2'b11
  } fmt_e;

  // Number of active bit-clock edges skipped between the frame edge and the MSB.
  function automatic int msb_slot(fmt_e f, int rj_off);
    case (f)
      FMT_LJ_DLY: return 1;
      FMT_RJ:     return rj_off;
      default:    return 0;
    endcase
  endfunction

  // Word length limited to the supported range.
  function automatic int clamp_len(int w, int lo, int hi);
    if (w < lo) return lo;
    if (w > hi) return hi;
    return w;
  endfunction

endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);

  logic [N-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur = sync_q;
  assign prv = hist_q;

endmodule

// File: rtl/srx_frame_ctl.sv
module srx_frame_ctl
  import srx_pkg::*;
#(
  parameter int MAX_WL = 16,
  parameter int MIN_WL = 4,
  parameter int RJ_OFF = 16,
  parameter int LEN_W  = 5,
  parameter int POS_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fmt,
  input  logic             bpol,
  input  logic [LEN_W-1:0] wlen,
  input  logic             bclk_cur,
  input  logic             bclk_prv,
  input  logic             lr_cur,
  input  logic             lr_prv,
  input  logic             wc_cur,
  input  logic             wc_prv,
  output logic             frame_evt,
  output logic             bit_evt,
  output logic             capture,
  output logic [POS_W-1:0] bit_pos,
  output logic             word_done,
  output logic             chan_left,
  output logic             armed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             chan_q;
  logic             wc_rise, lr_edge;
  int               len_i, off_i, slot_i, k_i;

  assign wc_rise = wc_cur & ~wc_prv;
  assign lr_edge = lr_cur ^ lr_prv;

  always_comb begin
    frame_evt = (fmt_e'(fmt) == FMT_WCLK) ? wc_rise : lr_edge;
    bit_evt   = bpol ? (~bclk_cur & bclk_prv) : (bclk_cur & ~bclk_prv);
    len_i     = clamp_len(int'(wlen), MIN_WL, MAX_WL);
    off_i     = msb_slot(fmt_e'(fmt), RJ_OFF);
    slot_i    = frame_evt ? 0 : int'(cnt_q);
    k_i       = slot_i - off_i;
    chan_left = frame_evt ? lr_cur : chan_q;
    capture   = bit_evt && (armed || frame_evt) && (k_i >= 0) && (k_i < len_i);
    bit_pos   = capture ? POS_W'(k_i) : '0;
    word_done = capture && (k_i == len_i - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      chan_q <= 1'b0;
      armed  <= 1'b0;
    end else if (frame_evt) begin
      armed  <= 1'b1;
      chan_q <= lr_cur;
      cnt_q  <= bit_evt ? CNT_W'(1) : '0;
    end else if (bit_evt && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/srx_word_asm.sv
module srx_word_asm #(
  parameter int MAX_WL = 16,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_evt,
  input  logic              capture,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              din,
  output logic [MAX_WL-1:0] word_next
);

  logic [MAX_WL-1:0] word_q;

  always_comb begin
    word_next = frame_evt ? '0 : word_q;
    for (int i = 0; i < MAX_WL; i++) begin
      if (capture && int'(bit_pos) == MAX_WL - 1 - i) word_next[i] = din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        word_q <= '0;
    else if (frame_evt || capture)  word_q <= word_next;
  end

endmodule

// File: rtl/srx_multifmt.sv
module srx_multifmt #(
  parameter int MAX_WL = 16,
  parameter int MIN_WL = 4,
  parameter int RJ_OFF = 16,
  parameter int LEN_W  = $clog2(MAX_WL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              wclk_i,
  input  logic [1:0]        fmt_i,
  input  logic              bpol_i,
  input  logic [LEN_W-1:0]  wlen_i,
  output logic [MAX_WL-1:0] left_o,
  output logic [MAX_WL-1:0] right_o,
  output logic              left_vld_o,
  output logic              right_vld_o
);

  localparam int POS_W = $clog2(MAX_WL);
  localparam int CNT_W = $clog2(RJ_OFF + MAX_WL + 2);

  logic [2:0]        clk_cur, clk_prv;
  logic              data_meta, data_sync;
  logic              bclk_lvl;
  logic              frame_evt, bit_evt, capture, word_done, chan_left, armed;
  logic [POS_W-1:0]  bit_pos;
  logic [MAX_WL-1:0] word_next;

  // Clock lines: [2]=word clock, [1]=channel clock, [0]=bit clock.
  srx_edge_sync #(.N(3)) u_clk_sync (
    .clk (clk),
    .rst (rst),
    .din ({wclk_i, lrck_i, bclk_i}),
    .cur (clk_cur),
    .prv (clk_prv)
  );

  // Data takes the same two-flop delay as the clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_meta <= 1'b0;
      data_sync <= 1'b0;
    end else begin
      data_meta <= sdata_i;
      data_sync <= data_meta;
    end
  end

  assign bclk_lvl = clk_cur[0];

  srx_frame_ctl #(
    .MAX_WL (MAX_WL),
    .MIN_WL (MIN_WL),
    .RJ_OFF (RJ_OFF),
    .LEN_W  (LEN_W),
    .POS_W  (POS_W),
    .CNT_W  (CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt_i),
    .bpol      (bpol_i),
    .wlen      (wlen_i),
    .bclk_cur  (clk_cur[0]),
    .bclk_prv  (clk_prv[0]),
    .lr_cur    (clk_cur[1]),
    .lr_prv    (clk_prv[1]),
    .wc_cur    (clk_cur[2]),
    .wc_prv    (clk_prv[2]),
    .frame_evt (frame_evt),
    .bit_evt   (bit_evt),
    .capture   (capture),
    .bit_pos   (bit_pos),
    .word_done (word_done),
    .chan_left (chan_left),
    .armed     (armed)
  );

  srx_word_asm #(
    .MAX_WL (MAX_WL),
    .POS_W  (POS_W)
  ) u_asm (
    .clk       (clk),
    .rst       (rst),
    .frame_evt (frame_evt),
    .capture   (capture),
    .bit_pos   (bit_pos),
    .din       (data_sync),
    .word_next (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      left_vld_o  <= word_done && chan_left;
      right_vld_o <= word_done && !chan_left;
      if (word_done && chan_left)  left_o  <= word_next;
      if (word_done && !chan_left) right_o <= word_next;
    end
  end

endmodule

// File: rtl/srx_checks.sv
module srx_checks #(
  parameter int MAX_WL = 16,
  parameter int MIN_WL = 4,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bpol_i,
  input logic [LEN_W-1:0]  wlen_i,
  input logic              bclk_lvl,
  input logic              bit_evt,
  input logic              frame_evt,
  input logic              armed,
  input logic [MAX_WL-1:0] left_o,
  input logic [MAX_WL-1:0] right_o,
  input logic              left_vld_o,
  input logic              right_vld_o
);

  logic [MAX_WL-1:0] tail_mask;

  always_comb begin
    int len;
    len = srx_pkg::clamp_len(int'(wlen_i), MIN_WL, MAX_WL);
    for (int i = 0; i < MAX_WL; i++) tail_mask[i] = (i < MAX_WL - len);
  end

  assert_sample_edge_R2: assert property (@(posedge clk) disable iff (rst)
    bit_evt |-> (bclk_lvl == !bpol_i));

  assert_left_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !left_vld_o |-> $stable(left_o));

  assert_right_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !right_vld_o |-> $stable(right_o));

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (left_vld_o || right_vld_o) |->
      (((left_vld_o ? left_o : right_o) & tail_mask) == '0));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(left_vld_o && right_vld_o));

  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (rst)
    (left_vld_o || right_vld_o) |=> !(left_vld_o || right_vld_o));

  assert_wait_frame_R11: assert property (@(posedge clk) disable iff (rst)
    (!armed && !frame_evt) |=> !(left_vld_o || right_vld_o));

endmodule

bind srx_multifmt srx_checks #(
  .MAX_WL (MAX_WL),
  .MIN_WL (MIN_WL),
  .LEN_W  (LEN_W)
) u_srx_checks (
  .clk         (clk),
  .rst         (rst),
  .bpol_i      (bpol_i),
  .wlen_i      (wlen_i),
  .bclk_lvl    (bclk_lvl),
  .bit_evt     (bit_evt),
  .frame_evt   (frame_evt),
  .armed       (armed),
  .left_o      (left_o),
  .right_o     (right_o),
  .left_vld_o  (left_vld_o),
  .right_vld_o (right_vld_o)
);

// File: tb/srx_multifmt_bench.sv
`timescale 1ns/1ps
module srx_multifmt_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdata = 1'b0, bclk = 1'b0, lrck = 1'b0, wclk = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        bpol = 1'b0;
  logic [4:0]  wlen = 5'd16;
  logic [15:0] left_o, right_o;
  logic        left_vld_o, right_vld_o;

  always #4 clk = ~clk;

  srx_multifmt u_srx_multifmt (
    .clk (clk), .rst (rst), .sdata_i (sdata), .bclk_i (bclk), .lrck_i (lrck),
    .wclk_i (wclk), .fmt_i (fmt), .bpol_i (bpol), .wlen_i (wlen),
    .left_o (left_o), .right_o (right_o),
    .left_vld_o (left_vld_o), .right_vld_o (right_vld_o)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0, model_on = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0]  pin_hist [$];   // {wclk, lrck, bclk, sdata}, newest first
  bit          m_arm, m_ch, m_lv, m_rv;
  int          m_cnt;
  logic [15:0] m_acc, m_l, m_r;

  function automatic int skip_of(logic [1:0] f);
    if (f == 2'b01) return 1;
    if (f == 2'b10) return 16;
    return 0;
  endfunction

  function automatic int len_of(logic [4:0] w);
    if (w < 4) return 4;
    if (w > 16) return 16;
    return int'(w);
  endfunction

  always @(posedge clk) begin
    logic [3:0] now_s, old_s;
    bit fe, ev;
    int slot, k, len;
    pin_hist.push_front(rst ? 4'b0 : {wclk, lrck, bclk, sdata});
    while (pin_hist.size() > 4) void'(pin_hist.pop_back());
    if (rst) begin
      m_arm = 0; m_ch = 0; m_cnt = 0; m_acc = '0;
      m_l = '0; m_r = '0; m_lv = 0; m_rv = 0;
    end else if (pin_hist.size() == 4) begin
      now_s = pin_hist[2];
      old_s = pin_hist[3];
      m_lv = 0; m_rv = 0;
      len = len_of(wlen);
      fe = (fmt == 2'b11) ? (now_s[3] && !old_s[3]) : (now_s[2] != old_s[2]);
      ev = bpol ? (!now_s[1] && old_s[1]) : (now_s[1] && !old_s[1]);
      slot = m_cnt;
      if (fe) begin
        m_arm = 1; m_ch = now_s[2]; m_acc = '0; slot = 0;
      end
      if (ev && m_arm) begin
        k = slot - skip_of(fmt);
        if (k >= 0 && k < len) begin
          m_acc[15-k] = now_s[0];
          if (k == len - 1) begin
            if (m_ch) begin m_l = m_acc; m_lv = 1; end
            else      begin m_r = m_acc; m_rv = 1; end
          end
        end
      end
      if (fe)               m_cnt = ev ? 1 : 0;
      else if (ev && m_cnt < 63) m_cnt = m_cnt + 1;
    end
  end

  // ---------------- per-cycle comparison and strobe bookkeeping ----------------
  logic [15:0] got_l, got_r;
  int          n_strobes = 0;
  bit          prev_any = 0;
  int          strobe_faults = 0;

  always @(negedge clk) begin
    if (model_on) begin
      check("R7 R10 cycle model {lv,rv,left,right}",
            {30'd0, left_vld_o, right_vld_o, left_o, right_o},
            {30'd0, m_lv, m_rv, m_l, m_r});
      if (left_vld_o && right_vld_o) strobe_faults++;
      if (prev_any && (left_vld_o || right_vld_o)) strobe_faults++;
      prev_any = left_vld_o || right_vld_o;
      if (left_vld_o)  begin got_l = left_o;  n_strobes++; end
      if (right_vld_o) begin got_r = right_o; n_strobes++; end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_bit(bit pol, bit d, bit lr, bit wc, int pause);
    @(negedge clk);
    bclk = pol; sdata = d; lrck = lr; wclk = wc;
    repeat (3 + pause) @(negedge clk);
    bclk = ~pol;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] aligned(logic [15:0] v, int len);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < len; i++) r[15-i] = v[len-1-i];
    return r;
  endfunction

  task automatic send_frame(string tag, logic [1:0] m, bit pol, int len,
                            logic [15:0] lv, logic [15:0] rv, bit gap);
    int skip;
    @(negedge clk);
    fmt = m; bpol = pol; wlen = 5'(len);
    @(negedge clk);
    bclk = pol;
    repeat (6) @(negedge clk);
    skip = (m == 2'b11) ? 3 : skip_of(m);
    got_l = 16'hdead; got_r = 16'hdead;
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < 32; s++) begin
        int k;
        bit d, wc;
        logic [15:0] val;
        val = (h == 0) ? lv : rv;
        k = s - skip;
        d = (k >= 0 && k < len) ? val[len-1-k] : 1'($urandom);
        wc = (m == 2'b11) ? (s >= 3 && s < 12) : (s >= 7 && s < 9);
        drive_bit(pol, d, (h == 0), wc, (gap && s == skip + 2) ? 40 : 0);
      end
    end
    repeat (8) @(negedge clk);
    check({tag, " left"},  {48'd0, got_l}, {48'd0, aligned(lv, len)});
    check({tag, " right"}, {48'd0, got_r}, {48'd0, aligned(rv, len)});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 outputs during reset", {30'd0, left_vld_o, right_vld_o, left_o, right_o}, 64'd0);
    rst = 1'b0;
    model_on = 1;
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", {30'd0, left_vld_o, right_vld_o, left_o, right_o}, 64'd0);

    // R11: bits arrive with no frame edge, nothing may be captured.
    for (int i = 0; i < 20; i++) drive_bit(1'b0, 1'b1, 1'b0, 1'b0, 0);
    repeat (6) @(negedge clk);
    check("R11 no strobe before first frame edge", 64'(n_strobes), 64'd0);

    send_frame("R3 R7 fmt00 rising len16",  2'b00, 1'b0, 16, 16'hA5C3, 16'h1234, 1'b0);
    send_frame("R2 fmt00 falling len16",    2'b00, 1'b1, 16, 16'h5A3C, 16'hFEDC, 1'b0);
    send_frame("R4 R8 fmt01 len12",         2'b01, 1'b0, 12, 16'h0ABC, 16'h0321, 1'b0);
    send_frame("R5 fmt10 len16",            2'b10, 1'b0, 16, 16'h8001, 16'h7FFE, 1'b0);
    send_frame("R5 R8 fmt10 len8 falling",  2'b10, 1'b1, 8,  16'h00C5, 16'h003A, 1'b0);
    send_frame("R6 fmt11 wordclock",        2'b11, 1'b0, 16, 16'h1357, 16'h2468, 1'b0);
    send_frame("R6 R2 fmt11 len10 falling", 2'b11, 1'b1, 10, 16'h02AA, 16'h0155, 1'b0);
    send_frame("R8 fmt00 len4",             2'b00, 1'b0, 4,  16'h0009, 16'h0006, 1'b0);
    send_frame("R8 len above range acts 16",2'b00, 1'b0, 31, 16'hC0DE, 16'h0BAD, 1'b0);
    send_frame("R9 gated bit clock fmt00",  2'b00, 1'b0, 16, 16'h9876, 16'h4321, 1'b1);
    send_frame("R9 gated bit clock fmt01",  2'b01, 1'b1, 14, 16'h2D2D, 16'h12E1, 1'b1);

    // R1 again: a reset in the middle of operation clears the outputs.
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs after mid-run reset", {30'd0, left_vld_o, right_vld_o, left_o, right_o}, 64'd0);
    rst = 1'b0;
    send_frame("R1 R3 first frame after reset", 2'b00, 1'b0, 16, 16'h0F0F, 16'hF0F0, 1'b0);

    check("R10 strobe shape faults", 64'(strobe_faults), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule